// File: doc/BRIEF.md
# Intra 4x4 Block Predictor

This unit forms the 4x4 intra prediction of an 8-bit luma block from its already reconstructed neighbours. The caller presents the four pixels of the column to the left, eight pixels of the row above (four directly above and four beyond the right edge), the single corner pixel above-left, a mode code and three availability flags. One clock later the block returns the sixteen predicted pixels as four packed rows, with a valid pulse.

Nine prediction modes are covered: plain vertical and horizontal copies, a DC mean that adapts to the sides that exist, and six angular modes. The angular modes use a two-tap rounding mean and a three-tap smoothing filter. The three-tap filter is built from per-byte halving add and halving subtract steps and gives the same bits as the direct rounding formula. When the above-right pixels are flagged absent, the modes that reach them repeat the last above pixel in their place. Codes past the last mode are rejected with an error flag.

Top module: `intra4_pred`

## Requirements
- R1: Mode code 0 (vertical) copies above pixels 0..3 into every row. A row is packed with pixel x in bits [8x+7:8x], so pixel 0 sits in the low byte.
- R2: Mode code 1 (horizontal) fills all four pixels of row r with left pixel r.
- R3: Mode code 2 (DC) with availability bits 0 (upper) and 1 (left) both set gives (sum of above 0..3 + sum of left 0..3 + 4) >> 3 in all 16 pixels.
- R4: Mode code 2 with only one of those two bits set gives (sum of that side's four pixels + 2) >> 2 in all pixels. Availability bit 2 (upper-right) has no effect on DC.
- R5: Mode code 2 with bits 0 and 1 both clear gives 128 in every pixel.
- R6: Every filtered pixel equals (a + 2b + c + 2) >> 2 exactly, including at the extremes 0 and 255. Every two-tap pixel equals (a + b + 1) >> 1.
- R7: With availability bit 2 clear, modes 3 and 7 use above pixel 3 in place of above pixels 4..7. With the bit set, they use the supplied values.
- R8: Mode code 3 (diagonal down-left): pixel (x,y) is the three-tap filter centred on above pixel x+y+1. Pixel (3,3) is (U6 + 3*U7 + 2) >> 2.
- R9: Mode codes 4 (diagonal down-right), 5 (vertical-right) and 6 (horizontal-down) follow the standard 4x4 formulas. They draw on the corner, left 0..3 and above 0..3.
- R10: Mode code 7 (vertical-left): even rows are two-tap means and odd rows are three-tap filters of the above row, each shifted by y/2.
- R11: Mode code 8 (horizontal-up): pixels with x+2y greater than 5 equal left pixel 3. Pixel (1,2) is (L2 + 3*L3 + 2) >> 2. The rest interleave two-tap means and three-tap filters down the left column.
- R12: Mode codes 9..15 raise the error flag with the valid pulse and drive all rows to zero.
- R13: Rows, error flag and valid appear on the clock edge after the one that accepts in_valid. In cycles without in_valid, valid is low and the rows keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Neighbours and mode are presented this cycle |
| mode_i | input | 4 | Prediction mode code, 0..8 legal |
| avail_i | input | 3 | Availability: bit 0 upper, bit 1 left, bit 2 upper-right |
| left_i | input | 32 | Left column, pixel k in bits [8k+7:8k], k=0 top |
| above_i | input | 64 | Above row 0..7, pixel k in bits [8k+7:8k] |
| corner_i | input | 8 | Above-left corner pixel |
| out_valid | output | 1 | Prediction rows are valid |
| err_o | output | 1 | Mode code was out of range |
| row0_o | output | 32 | Predicted row 0, pixel 0 in low byte |
| row1_o | output | 32 | Predicted row 1 |
| row2_o | output | 32 | Predicted row 2 |
| row3_o | output | 32 | Predicted row 3 |

## Verification
Above-right substitution and the edge-repeat tail of the diagonal filters can both act on the same pixel in one cycle. In diagonal down-left, pixel (3,3) both reaches above pixel 7 and repeats it. The bench provokes this by sending modes 3 and 7 with the upper-right bit clear while above pixels 4..7 carry values unlike pixel 3. It then sends the same data with the bit set. All sixteen pixels are compared against a reference that substitutes first and applies the rounding formulas directly. Filter extremes (all 0, all 255, alternating) are run through the same comparison.

// File: rtl/intra4_pkg.sv
package intra4_pkg;

   typedef enum logic [3:0] {
      M_VERT = 4'd0, M_HORZ = 4'd1, M_DC  = 4'd2, M_DDL = 4'd3, M_DDR = 4'd4,
      M_VR   = 4'd5, M_HD   = 4'd6, M_VL  = 4'd7, M_HU  = 4'd8
   } pmode_e;

   localparam int NUM_MODES = 9;
   localparam int BLK       = 4;
   localparam int EDGE_N    = 2 * BLK + 1 + BLK;   // left, corner, above 0..7
   localparam int SLOT_W    = $clog2(EDGE_N);
   localparam int AV_UP     = 0;
   localparam int AV_LEFT   = 1;
   localparam int AV_UR     = 2;

   typedef enum logic [1:0] {OP_COPY, OP_AVG, OP_TAP3, OP_DC} op_e;

   typedef struct packed {
      op_e               op;
      logic [SLOT_W-1:0] a;
      logic [SLOT_W-1:0] b;
      logic [SLOT_W-1:0] c;
   } tap_t;

   // edge slot layout: L3 L2 L1 L0 Q U0 .. U7 ; index -1 on either side is Q
   function automatic int sl(input int k); return 3 - k; endfunction
   function automatic int su(input int k); return 5 + k; endfunction

   function automatic tap_t mk(input op_e op, input int a, input int b, input int c);
      tap_t t;
      t.op = op;
      t.a  = SLOT_W'(a);
      t.b  = SLOT_W'(b);
      t.c  = SLOT_W'(c);
      return t;
   endfunction

   function automatic tap_t tap_plan(input logic [3:0] m, input int x, input int y);
      int z;
      tap_t t;
      t = mk(OP_COPY, 0, 0, 0);
      case (m)
         M_VERT: t = mk(OP_COPY, su(x), 0, 0);
         M_HORZ: t = mk(OP_COPY, sl(y), 0, 0);
         M_DC:   t = mk(OP_DC, 0, 0, 0);
         M_DDL: begin
            if (x == 3 && y == 3) t = mk(OP_TAP3, su(6), su(7), su(7));
            else                  t = mk(OP_TAP3, su(x+y), su(x+y+1), su(x+y+2));
         end
         M_DDR: t = mk(OP_TAP3, 3+x-y, 4+x-y, 5+x-y);
         M_VR: begin
            z = 2*x - y;
            if (z >= 0 && z % 2 == 0)  t = mk(OP_AVG,  su(x-y/2-1), su(x-y/2), 0);
            else if (z >= 0)           t = mk(OP_TAP3, su(x-y/2-2), su(x-y/2-1), su(x-y/2));
            else if (z == -1)          t = mk(OP_TAP3, sl(0), 4, su(0));
            else                       t = mk(OP_TAP3, 4-y, 5-y, 6-y);
         end
         M_HD: begin
            z = 2*y - x;
            if (z >= 0 && z % 2 == 0)  t = mk(OP_AVG,  sl(y-x/2-1), sl(y-x/2), 0);
            else if (z >= 0)           t = mk(OP_TAP3, sl(y-x/2-2), sl(y-x/2-1), sl(y-x/2));
            else if (z == -1)          t = mk(OP_TAP3, sl(0), 4, su(0));
            else                       t = mk(OP_TAP3, su(x-1), su(x-2), su(x-3));
         end
         M_VL: begin
            if (y % 2 == 0) t = mk(OP_AVG,  su(x+y/2), su(x+y/2+1), 0);
            else            t = mk(OP_TAP3, su(x+y/2), su(x+y/2+1), su(x+y/2+2));
         end
         M_HU: begin
            z = x + 2*y;
            if (z > 5)            t = mk(OP_COPY, sl(3), 0, 0);
            else if (z == 5)      t = mk(OP_TAP3, sl(2), sl(3), sl(3));
            else if (z % 2 == 0)  t = mk(OP_AVG,  sl(y+x/2), sl(y+x/2+1), 0);
            else                  t = mk(OP_TAP3, sl(y+x/2), sl(y+x/2+1), sl(y+x/2+2));
         end
         default: t = mk(OP_COPY, 0, 0, 0);
      endcase
      return t;
   endfunction

endpackage

// File: rtl/intra4_tap.sv
module intra4_tap #(
   parameter int PIX_W   = 8,
   parameter bit HALVING = 1'b1
) (
   input  logic [PIX_W-1:0] a_i,
   input  logic [PIX_W-1:0] b_i,
   input  logic [PIX_W-1:0] c_i,
   output logic [PIX_W-1:0] avg_o,
   output logic [PIX_W-1:0] tap3_o
);
   localparam logic [PIX_W-1:0] BIAS = {1'b1, {(PIX_W-1){1'b0}}};

   logic [PIX_W:0] pair_ab;
   assign pair_ab = {1'b0, a_i} + {1'b0, b_i} + (PIX_W+1)'(1);
   assign avg_o   = pair_ab[PIX_W:1];

   generate
      if (HALVING) begin : g_halving
         logic [PIX_W:0]   pair_ac;
         logic [PIX_W-1:0] half_ac;
         logic [PIX_W+1:0] diff;
         logic [PIX_W+1:0] direct_s;
         assign pair_ac = {1'b0, a_i} + {1'b0, c_i};
         assign half_ac = pair_ac[PIX_W:1];
         // halving subtract of the complemented centre tap
         assign diff    = {2'b00, half_ac} - {2'b00, ~b_i};
         assign tap3_o  = diff[PIX_W:1] + BIAS;
         assign direct_s = {2'b00, a_i} + {1'b0, b_i, 1'b0} + {2'b00, c_i} + (PIX_W+2)'(2);
         always_comb begin
            if (!$isunknown({a_i, b_i, c_i})) begin
               // R6
               tap3_exact_chk: assert (tap3_o == direct_s[PIX_W+1:2])
                  else $error("halving filter disagrees with direct formula");
            end
         end
      end else begin : g_direct
         logic [PIX_W+1:0] sum3;
         assign sum3   = {2'b00, a_i} + {1'b0, b_i, 1'b0} + {2'b00, c_i} + (PIX_W+2)'(2);
         assign tap3_o = sum3[PIX_W+1:2];
      end
   endgenerate
endmodule

// File: rtl/intra4_dc.sv
module intra4_dc #(
   parameter int PIX_W = 8
) (
   input  logic [4*PIX_W-1:0] left_i,
   input  logic [4*PIX_W-1:0] above_i,
   input  logic               use_up_i,
   input  logic               use_left_i,
   output logic [PIX_W-1:0]   dc_o
);
   localparam int SW = PIX_W + 3;
   localparam logic [PIX_W-1:0] MID = {1'b1, {(PIX_W-1){1'b0}}};

   logic [SW-1:0] sum_l, sum_u, both, res;

   always_comb begin
      sum_l = '0;
      sum_u = '0;
      for (int k = 0; k < 4; k++) begin
         sum_l = sum_l + SW'(left_i[k*PIX_W +: PIX_W]);
         sum_u = sum_u + SW'(above_i[k*PIX_W +: PIX_W]);
      end
      both = sum_l + sum_u + SW'(4);
      case ({use_up_i, use_left_i})
         2'b11:   res = both >> 3;
         2'b10:   res = (sum_u + SW'(2)) >> 2;
         2'b01:   res = (sum_l + SW'(2)) >> 2;
         default: res = SW'(MID);
      endcase
      dc_o = res[PIX_W-1:0];
   end
endmodule

// File: rtl/intra4_core.sv
module intra4_core
   import intra4_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter bit HALVING = 1'b1
) (
   input  logic [3:0]          mode_i,
   input  logic [2:0]          avail_i,
   input  logic [4*PIX_W-1:0]  left_i,
   input  logic [8*PIX_W-1:0]  above_i,
   input  logic [PIX_W-1:0]    corner_i,
   output logic [16*PIX_W-1:0] pix_o,
   output logic                bad_o
);
   localparam int SLOTS = 1 << SLOT_W;

   logic [PIX_W-1:0] edge_v [SLOTS];
   logic [PIX_W-1:0] top3;
   logic [PIX_W-1:0] dc_v;

   assign top3  = above_i[4*PIX_W-1 -: PIX_W];
   assign bad_o = (mode_i >= 4'(NUM_MODES));

   always_comb begin
      for (int s = 0; s < SLOTS; s++) edge_v[s] = '0;
      for (int k = 0; k < 4; k++) edge_v[sl(k)] = left_i[k*PIX_W +: PIX_W];
      edge_v[4] = corner_i;
      for (int k = 0; k < 4; k++) edge_v[su(k)] = above_i[k*PIX_W +: PIX_W];
      for (int k = 4; k < 8; k++)
         edge_v[su(k)] = avail_i[AV_UR] ? above_i[k*PIX_W +: PIX_W] : top3;
   end

   intra4_dc #(.PIX_W(PIX_W)) u_dc (
      .left_i    (left_i),
      .above_i   (above_i[4*PIX_W-1:0]),
      .use_up_i  (avail_i[AV_UP]),
      .use_left_i(avail_i[AV_LEFT]),
      .dc_o      (dc_v)
   );

   generate
      for (genvar gy = 0; gy < BLK; gy++) begin : g_row
         for (genvar gx = 0; gx < BLK; gx++) begin : g_col
            tap_t             plan;
            logic [PIX_W-1:0] ta, tb, tc, avg_v, t3_v, pv;
            always_comb plan = tap_plan(mode_i, gx, gy);
            assign ta = edge_v[plan.a];
            assign tb = edge_v[plan.b];
            assign tc = edge_v[plan.c];
            intra4_tap #(.PIX_W(PIX_W), .HALVING(HALVING)) u_tap (
               .a_i   (ta),
               .b_i   (tb),
               .c_i   (tc),
               .avg_o (avg_v),
               .tap3_o(t3_v)
            );
            always_comb begin
               case (plan.op)
                  OP_COPY: pv = ta;
                  OP_AVG:  pv = avg_v;
                  OP_TAP3: pv = t3_v;
                  default: pv = dc_v;
               endcase
            end
            assign pix_o[(gy*BLK+gx)*PIX_W +: PIX_W] = pv;
         end
      end
   endgenerate
endmodule

// File: rtl/intra4_pred.sv
module intra4_pred #(
   parameter int PIX_W   = 8,
   parameter bit HALVING = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [3:0]         mode_i,
   input  logic [2:0]         avail_i,
   input  logic [4*PIX_W-1:0] left_i,
   input  logic [8*PIX_W-1:0] above_i,
   input  logic [PIX_W-1:0]   corner_i,
   output logic               out_valid,
   output logic               err_o,
   output logic [4*PIX_W-1:0] row0_o,
   output logic [4*PIX_W-1:0] row1_o,
   output logic [4*PIX_W-1:0] row2_o,
   output logic [4*PIX_W-1:0] row3_o
);
   localparam int ROW_W = 4 * PIX_W;

   initial begin
      pix_width_chk: assert (PIX_W >= 2) else $error("PIX_W must be at least 2");
   end

   logic [16*PIX_W-1:0] pix;
   logic                bad;

   intra4_core #(.PIX_W(PIX_W), .HALVING(HALVING)) u_core (
      .mode_i  (mode_i),
      .avail_i (avail_i),
      .left_i  (left_i),
      .above_i (above_i),
      .corner_i(corner_i),
      .pix_o   (pix),
      .bad_o   (bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         err_o     <= 1'b0;
         row0_o    <= '0;
         row1_o    <= '0;
         row2_o    <= '0;
         row3_o    <= '0;
      end else begin
         out_valid <= in_valid;
         err_o     <= in_valid & bad;
         if (in_valid) begin
            row0_o <= bad ? '0 : pix[0*ROW_W +: ROW_W];
            row1_o <= bad ? '0 : pix[1*ROW_W +: ROW_W];
            row2_o <= bad ? '0 : pix[2*ROW_W +: ROW_W];
            row3_o <= bad ? '0 : pix[3*ROW_W +: ROW_W];
         end
      end
   end

   // R12
   bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (row0_o == '0 && row1_o == '0 && row2_o == '0 && row3_o == '0));
   // R12
   err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> out_valid);
   // R1
   vert_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_i == 4'd0) |=>
      (row0_o == $past(above_i[ROW_W-1:0]) && row3_o == row0_o && row1_o == row2_o && row1_o == row0_o));
   // R2
   horz_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_i == 4'd1) |=> (row2_o == {4{$past(left_i[2*PIX_W +: PIX_W])}}));
   // R5
   dc_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_i == 4'd2 && avail_i[1:0] == 2'b00) |=>
      (row1_o == {4{1'b1, {(PIX_W-1){1'b0}}}}));
   // R7
   ddl_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_i == 4'd3 && !avail_i[2]) |=>
      (row3_o == {4{$past(above_i[3*PIX_W +: PIX_W])}}));
   // R11
   hu_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_i == 4'd8) |=> (row3_o == {4{$past(left_i[3*PIX_W +: PIX_W])}}));
   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(row0_o) && $stable(row3_o)));
endmodule

// File: tb/intra4_pred_bench.sv
module intra4_pred_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  mode_i = '0;
   logic [2:0]  avail_i = '0;
   logic [31:0] left_i = '0;
   logic [63:0] above_i = '0;
   logic [7:0]  corner_i = '0;
   logic        out_valid, err_o;
   logic [31:0] row0_o, row1_o, row2_o, row3_o;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   int tl [4];
   int tu [8];
   int tq;

   always #(CLK_PERIOD/2) clk = ~clk;

   intra4_pred u_intra4_pred (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_i(mode_i), .avail_i(avail_i),
      .left_i(left_i), .above_i(above_i), .corner_i(corner_i), .out_valid(out_valid),
      .err_o(err_o), .row0_o(row0_o), .row1_o(row1_o), .row2_o(row2_o), .row3_o(row3_o)
   );

   task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int f3(input int a, input int b, input int c);
      return (a + 2*b + c + 2) >> 2;
   endfunction
   function automatic int a2(input int a, input int b);
      return (a + b + 1) >> 1;
   endfunction

   // neighbour at column i, row j; -1 denotes the edge row/column
   function automatic int nb(input int i, input int j, input bit ur);
      if (i == -1 && j == -1) return tq;
      if (j == -1) return (i > 3 && !ur) ? tu[3] : tu[i];
      return tl[j];
   endfunction

   function automatic int ref_pix(input int m, input bit [2:0] av, input int x, input int y);
      int z, su, sl;
      bit ur;
      ur = av[2];
      case (m)
         0: return nb(x, -1, ur);
         1: return nb(-1, y, ur);
         2: begin
            su = tu[0] + tu[1] + tu[2] + tu[3];
            sl = tl[0] + tl[1] + tl[2] + tl[3];
            if (av[1:0] == 2'b11) return (su + sl + 4) >> 3;
            if (av[0]) return (su + 2) >> 2;
            if (av[1]) return (sl + 2) >> 2;
            return 128;
         end
         3: begin
            if (x == 3 && y == 3) return (nb(6,-1,ur) + 3*nb(7,-1,ur) + 2) >> 2;
            return f3(nb(x+y,-1,ur), nb(x+y+1,-1,ur), nb(x+y+2,-1,ur));
         end
         4: begin
            if (x > y) return f3(nb(x-y-2,-1,ur), nb(x-y-1,-1,ur), nb(x-y,-1,ur));
            if (x < y) return f3(nb(-1,y-x-2,ur), nb(-1,y-x-1,ur), nb(-1,y-x,ur));
            return f3(nb(0,-1,ur), tq, nb(-1,0,ur));
         end
         5: begin
            z = 2*x - y;
            if (z >= 0 && z % 2 == 0) return a2(nb(x-(y>>1)-1,-1,ur), nb(x-(y>>1),-1,ur));
            if (z >= 0) return f3(nb(x-(y>>1)-2,-1,ur), nb(x-(y>>1)-1,-1,ur), nb(x-(y>>1),-1,ur));
            if (z == -1) return f3(nb(-1,0,ur), tq, nb(0,-1,ur));
            return f3(nb(-1,y-1,ur), nb(-1,y-2,ur), nb(-1,y-3,ur));
         end
         6: begin
            z = 2*y - x;
            if (z >= 0 && z % 2 == 0) return a2(nb(-1,y-(x>>1)-1,ur), nb(-1,y-(x>>1),ur));
            if (z >= 0) return f3(nb(-1,y-(x>>1)-2,ur), nb(-1,y-(x>>1)-1,ur), nb(-1,y-(x>>1),ur));
            if (z == -1) return f3(nb(-1,0,ur), tq, nb(0,-1,ur));
            return f3(nb(x-1,-1,ur), nb(x-2,-1,ur), nb(x-3,-1,ur));
         end
         7: begin
            if (y % 2 == 0) return a2(nb(x+(y>>1),-1,ur), nb(x+(y>>1)+1,-1,ur));
            return f3(nb(x+(y>>1),-1,ur), nb(x+(y>>1)+1,-1,ur), nb(x+(y>>1)+2,-1,ur));
         end
         default: begin
            z = x + 2*y;
            if (z > 5) return tl[3];
            if (z == 5) return (tl[2] + 3*tl[3] + 2) >> 2;
            if (z % 2 == 0) return a2(tl[y+(x>>1)], tl[y+(x>>1)+1]);
            return f3(tl[y+(x>>1)], tl[y+(x>>1)+1], tl[y+(x>>1)+2]);
         end
      endcase
   endfunction

   task automatic load_rand();
      for (int k = 0; k < 4; k++) tl[k] = int'($urandom_range(0, 255));
      for (int k = 0; k < 8; k++) tu[k] = int'($urandom_range(0, 255));
      tq = int'($urandom_range(0, 255));
   endtask

   task automatic load_fill(input int lv, input int uv, input int qv, input bit alt);
      for (int k = 0; k < 4; k++) tl[k] = (alt && k % 2 == 1) ? 255 - lv : lv;
      for (int k = 0; k < 8; k++) tu[k] = (alt && k % 2 == 1) ? 255 - uv : uv;
      tq = qv;
   endtask

   task automatic drive(input int m, input bit [2:0] av);
      @(negedge clk);
      for (int k = 0; k < 4; k++) left_i[k*8 +: 8] = 8'(tl[k]);
      for (int k = 0; k < 8; k++) above_i[k*8 +: 8] = 8'(tu[k]);
      corner_i = 8'(tq);
      mode_i   = 4'(m);
      avail_i  = av;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_block(input int m, input bit [2:0] av, input string req);
      logic [127:0] exp, act;
      drive(m, av);
      for (int y = 0; y < 4; y++)
         for (int x = 0; x < 4; x++)
            exp[y*32 + x*8 +: 8] = 8'(ref_pix(m, av, x, y));
      act = {row3_o, row2_o, row1_o, row0_o};
      check(act == exp && out_valid && !err_o, req, act, exp);
   endtask

   task automatic t_reset();
      check(!out_valid && !err_o && {row3_o, row2_o, row1_o, row0_o} == '0, "R13 reset",
            {row3_o, row2_o, row1_o, row0_o}, '0);
   endtask

   task automatic t_vertical();
      for (int i = 0; i < 3; i++) begin load_rand(); run_block(0, 3'(i), "R1 vertical"); end
   endtask

   task automatic t_horizontal();
      for (int i = 0; i < 3; i++) begin load_rand(); run_block(1, 3'(7 - i), "R2 horizontal"); end
   endtask

   task automatic t_dc();
      for (int a = 0; a < 8; a++) begin
         load_rand();
         if (a[1:0] == 2'b11)      run_block(2, 3'(a), "R3 dc both");
         else if (a[1:0] == 2'b00) run_block(2, 3'(a), "R5 dc none");
         else                      run_block(2, 3'(a), "R4 dc one side");
      end
      load_fill(255, 255, 0, 0);
      run_block(2, 3'b011, "R3 dc max");
   endtask

   task automatic t_filter_extremes();
      load_fill(255, 255, 255, 0); run_block(4, 3'b111, "R6 all ones");
      load_fill(0, 0, 0, 0);       run_block(5, 3'b111, "R6 all zero");
      load_fill(0, 255, 255, 1);   run_block(6, 3'b111, "R6 alternating");
      load_fill(255, 0, 0, 1);     run_block(3, 3'b111, "R6 alternating ddl");
   endtask

   task automatic t_subst();
      for (int i = 0; i < 3; i++) begin
         load_rand();
         tu[4] = tu[3] ^ 8'h55; tu[5] = tu[3] ^ 8'hAA; tu[6] = tu[3] ^ 8'h0F; tu[7] = tu[3] ^ 8'hF0;
         run_block(3, 3'b011, "R7 ddl no upper-right");
         run_block(3, 3'b111, "R8 ddl with upper-right");
         run_block(7, 3'b001, "R7 vl no upper-right");
         run_block(7, 3'b100, "R10 vl with upper-right");
      end
   endtask

   task automatic t_corner_modes();
      for (int i = 0; i < 4; i++) begin
         load_rand();
         run_block(4, 3'(i), "R9 diag down-right");
         run_block(5, 3'(i), "R9 vertical-right");
         run_block(6, 3'(i), "R9 horizontal-down");
      end
   endtask

   task automatic t_hu();
      for (int i = 0; i < 3; i++) begin load_rand(); run_block(8, 3'(i), "R11 horizontal-up"); end
   endtask

   task automatic t_invalid();
      for (int m = 9; m < 16; m++) begin
         load_rand();
         drive(m, 3'b111);
         check(err_o && out_valid && {row3_o, row2_o, row1_o, row0_o} == '0, "R12 bad mode",
               {err_o, out_valid, row3_o, row2_o, row1_o, row0_o}, {2'b11, 96'h0});
      end
      load_rand();
      run_block(0, 3'b111, "R12 recovery after bad mode");
   endtask

   task automatic t_hold();
      logic [127:0] held;
      load_rand();
      run_block(4, 3'b111, "R13 latency");
      held = {row3_o, row2_o, row1_o, row0_o};
      @(negedge clk);
      left_i = ~left_i; above_i = ~above_i; mode_i = 4'd1;
      @(negedge clk);
      check(!out_valid && {row3_o, row2_o, row1_o, row0_o} == held, "R13 idle hold",
            {row3_o, row2_o, row1_o, row0_o}, held);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL R13 watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 3);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_vertical();
      t_horizontal();
      t_dc();
      t_filter_extremes();
      t_subst();
      t_corner_modes();
      t_hu();
      t_invalid();
      t_hold();
      finish_run();
   end
endmodule